// File: doc/BRIEF.md
# Global-History XOR Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a table of 2-bit saturating counters. The table is indexed by address bits of the branch, XORed with a shift register that records the directions of the most recent resolved branches. Because the recent path is part of the index, one branch can train several counters, one for each path that leads to it. This lets the block follow branches whose outcome depends on earlier branches.

The front end presents a fetch address and gets back, in the same cycle and without a clock edge, a taken/not-taken guess and the table index that produced it. The front end carries that index down the pipeline. When the branch resolves, the back end returns the index together with the real direction. The addressed counter then moves one step toward that direction, and the direction is shifted into the history. The index is always supplied from outside and is never recomputed, so a history that has moved on since the prediction cannot send the training to the wrong counter.

The index width `IDX_W` sets both the history length and the table depth (2^IDX_W counters). Its default is 10. A 13-bit setting gives the 8192-counter organisation.

Top module: `gshare_predictor`

## Requirements
- R1: After reset every counter holds 01 (weakly not-taken) and the history is all zeros, so every address predicts not-taken and reports index `pred_pc[IDX_W:1]`.
- R2: `pred_idx` equals `pred_pc[IDX_W:1]` XOR the history, combinationally. `pred_pc[0]` and the bits above `IDX_W` have no effect.
- R3: On a clock edge with `upd_valid` high, the history shifts left by one and `upd_taken` enters bit 0 (1 = taken).
- R4: `pred_taken` is bit 1 (the MSB) of the counter at `pred_idx`. Codes 10 and 11 predict taken; 00 and 01 predict not-taken.
- R5: An update with `upd_taken`=1 increments the counter at `upd_idx`, holding at 11.
- R6: An update with `upd_taken`=0 decrements the counter at `upd_idx`, holding at 00.
- R7: A single outcome against a strong state (11 or 00) only reaches the weak state on the same side, so the prediction does not change.
- R8: The update writes exactly the counter named by `upd_idx`, independent of the current history and of `pred_pc`.
- R9: When a prediction reads the counter that an update writes in the same cycle, the prediction shows the value held before the write.
- R10: With `upd_valid` low, neither the counters nor the history change, whatever `upd_taken` and `upd_idx` hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| pred_pc | input | PC_W | Fetch address to predict |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_idx | output | IDX_W | Table index used for this prediction |
| upd_valid | input | 1 | Resolved branch present this cycle |
| upd_taken | input | 1 | Resolved direction, 1 = taken |
| upd_idx | input | IDX_W | Index captured when the branch was predicted |

## Verification
`pred_taken` and `pred_idx` depend only on the present `pred_pc` and stored state, so they are due in the same cycle as the address. An update appears in both outputs from the cycle after the edge that takes it. The bench sets inputs just after the falling edge and compares both outputs one time unit later with a behavioural model. The model absorbs an update only after that comparison, so a prediction in the cycle of a write is checked against the value before the write. Index arithmetic, saturation at both ends and the ignored update fields are all seen through these two outputs.

// File: rtl/gshare_predictor.sv
module gshare_predictor #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PC_W-1:0]  pred_pc,
  output logic             pred_taken,
  output logic [IDX_W-1:0] pred_idx,
  input  logic             upd_valid,
  input  logic             upd_taken,
  input  logic [IDX_W-1:0] upd_idx
);
  localparam int DEPTH = 1 << IDX_W;

  logic [1:0]       ctr_q [DEPTH];
  logic [IDX_W-1:0] hist_q;
  logic [1:0]       cur, nxt;
  logic             unused_pc_bits;

  assign unused_pc_bits = ^{pred_pc[0], pred_pc[PC_W-1:IDX_W+1]};

  assign pred_idx   = pred_pc[IDX_W:1] ^ hist_q;
  assign pred_taken = ctr_q[pred_idx][1];

  assign cur = ctr_q[upd_idx];
  assign nxt = upd_taken ? ((cur == 2'b11) ? cur : cur + 2'd1)
                         : ((cur == 2'b00) ? cur : cur - 2'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ctr_q[i] <= 2'b01;
      hist_q <= '0;
    end else if (upd_valid) begin
      ctr_q[upd_idx] <= nxt;
      hist_q         <= {hist_q[IDX_W-2:0], upd_taken};
    end
  end
endmodule

module gshare_predictor_chk #(
  parameter int IDX_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             upd_valid,
  input logic             upd_taken,
  input logic [IDX_W-1:0] upd_idx,
  input logic [IDX_W-1:0] hist,
  input logic [1:0]       ctr [1 << IDX_W]
);
  logic [1:0] cur_c;
  assign cur_c = ctr[upd_idx];

  assert_hist_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> hist == {$past(hist[IDX_W-2:0]), $past(upd_taken)});

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> $stable(hist));

  assert_inc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_taken && cur_c != 2'b11) |=>
      ctr[$past(upd_idx)] == 2'($past(cur_c) + 2'd1));

  assert_dec_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_taken && cur_c != 2'b00) |=>
      ctr[$past(upd_idx)] == 2'($past(cur_c) - 2'd1));

  assert_sat_hi_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_taken && cur_c == 2'b11) |=> ctr[$past(upd_idx)] == 2'b11);

  assert_sat_lo_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_taken && cur_c == 2'b00) |=> ctr[$past(upd_idx)] == 2'b00);
endmodule

bind gshare_predictor gshare_predictor_chk #(.IDX_W(IDX_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_taken(upd_taken),
  .upd_idx(upd_idx), .hist(hist_q), .ctr(ctr_q)
);

// File: tb/gshare_predictor_tb_top.sv
module gshare_predictor_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W  = 32;
  localparam int IDX_W = 10;
  localparam int DEPTH = 1 << IDX_W;
  localparam int MASK  = DEPTH - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [PC_W-1:0]  pred_pc = '0;
  logic             pred_taken;
  logic [IDX_W-1:0] pred_idx;
  logic             upd_valid = 1'b0;
  logic             upd_taken = 1'b0;
  logic [IDX_W-1:0] upd_idx = '0;

  int m_ctr [DEPTH];
  int m_hist;
  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gshare_predictor #(.PC_W(PC_W), .IDX_W(IDX_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(pred_taken),
    .pred_idx(pred_idx), .upd_valid(upd_valid), .upd_taken(upd_taken),
    .upd_idx(upd_idx)
  );

  function automatic logic [PC_W-1:0] pc_for(input int idx);
    return 32'hA000_0000 | 32'(((idx ^ m_hist) & MASK) << 1) | 32'd1;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input logic [PC_W-1:0] pc, input logic uv, input logic ut,
                      input int ui, input string req);
    int e_idx;
    @(negedge clk);
    pred_pc = pc; upd_valid = uv; upd_taken = ut; upd_idx = ui[IDX_W-1:0];
    #1;
    e_idx = (int'(pc >> 1) & MASK) ^ m_hist;
    check({req, " index"}, int'(pred_idx), e_idx);
    check({req, " direction"}, int'(pred_taken), (m_ctr[e_idx] >= 2) ? 1 : 0);
    if (uv) begin
      if (ut && m_ctr[ui] < 3) m_ctr[ui]++;
      if (!ut && m_ctr[ui] > 0) m_ctr[ui]--;
      m_hist = ((m_hist << 1) | int'(ut)) & MASK;
    end
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    int a, b;
    for (int i = 0; i < DEPTH; i++) m_ctr[i] = 1;
    m_hist = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 / R2: reset state, index from address bits only
    step(32'h0000_0000, 0, 0, 0, "R1");
    step(32'h0000_07FE, 0, 0, 0, "R1");
    step(32'hFFFF_F3A5, 0, 0, 0, "R2");

    // R5 / R4 / R9: train entry a toward taken while predicting it
    a = 10'h155;
    for (int i = 0; i < 4; i++) step(pc_for(a), 1, 1, a, "R9");
    step(pc_for(a), 0, 0, 0, "R5");
    step(pc_for(a), 0, 0, 0, "R4");

    // R7: one not-taken from strong taken keeps taken prediction
    step(pc_for(a), 1, 0, a, "R7");
    step(pc_for(a), 0, 0, 0, "R7");

    // R6: drive down to the floor and past it
    for (int i = 0; i < 4; i++) step(pc_for(a), 1, 0, a, "R6");
    step(pc_for(a), 0, 0, 0, "R6");
    // R7: one taken from strong not-taken keeps not-taken
    step(pc_for(a), 1, 1, a, "R7");
    step(pc_for(a), 0, 0, 0, "R7");

    // R8: update b while history differs; b trained, neighbour untouched
    b = 10'h2A3;
    step(pc_for(b ^ 1), 1, 1, b, "R8");
    step(pc_for(b ^ 1), 1, 1, b, "R8");
    step(pc_for(b), 0, 0, 0, "R8");
    step(pc_for(b ^ 1), 0, 0, 0, "R8");

    // R10: stray fields with upd_valid low change nothing
    for (int i = 0; i < 3; i++) step(pc_for(b), 0, 1, b, "R10");
    step(32'h0000_0ABC, 0, 0, 0, "R10");

    // R3 / R2: mixed stream with history shifting
    for (int i = 0; i < 400; i++) begin
      logic [PC_W-1:0] pc;
      int ui;
      pc = $urandom;
      ui = (int'(pc >> 1) & MASK) ^ m_hist;
      step(pc, 1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 2) != 0),
           (i % 5 == 0) ? int'($urandom_range(0, MASK)) : ui, "R3");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule